// File: doc/BRIEF.md
# Programmable-Rate Video Pixel Serializer

The block turns 32-bit words of pixel data into a steady stream of pixels. The pace is set in ticks of a dedicated video clock. A scale register in the system clock domain holds two separately programmed periods:

- the number of video-clock ticks between successive pixels;
- the number of ticks each 32-bit word (a frame) occupies before the next word is taken.

Because the two periods are independent, a frame may end before every pixel of its word has been sent, or it may outlast them.

Words arrive over a valid/ready handshake in the video clock domain and are accepted only at frame boundaries. A mode input, sampled with each word, selects how the word is split: sixteen 2-bit pixels or thirty-two 1-bit pixels. The serializer presents the current pixel index on `pix_out` and marks each new pixel with a one-cycle `pix_stb`. If no word is waiting at a boundary, it does three things:

- it flags an underrun;
- it stops counting;
- it keeps ready asserted until a word arrives.

A new scale value written from the system side crosses into the video domain. It governs only frames that start after it has arrived.

Top module: `pixel_serializer`

## Requirements
- R1: A write (`scl_wr_en` high at a `sys_clk` edge) stores `scl_wr_data`. `scl_rd_data` then returns bits 19:0 as written and bits 31:20 as zero.
- R2: The pixel period P is taken from scale bits 19:12. After a word is accepted, pixel k is strobed exactly k·P video cycles after pixel 0. A field value of 0 means P = 256.
- R3: The frame period F is taken from scale bits 11:0. `word_ready` is high in the last cycle of a frame, and a waiting word is accepted F cycles after the previous one. A field value of 0 means F = 4096.
- R4: With `word_mode` = 0 the word carries 16 pixels of 2 bits, and pixel n is bits [2n+1:2n]. With `word_mode` = 1 it carries 32 pixels of 1 bit, and pixel n is bit n, output as `pix_out` = {0, bit}. Pixels are sent least significant first, and the mode is sampled when the word is accepted.
- R5: In the cycle after a word is accepted, `pix_stb` is high and `pix_out` shows pixel 0. While a frame is running and not in its last cycle, `word_ready` is low.
- R6: When the frame period ends before all pixels of the word are out, the remaining pixels are dropped, with no strobe for them, and the next word begins.
- R7: When the pixels run out before the frame period ends, `pix_out` holds the last pixel and `pix_stb` stays low until the frame ends.
- R8: If no word is valid at a frame boundary:
  - `underrun` is high for one cycle;
  - `word_ready` stays high;
  - no pixel is strobed until a word is accepted.

  No underrun is flagged while idle after reset.
- R9: A scale value written while a frame is running leaves that frame's timing unchanged. It governs the next word accepted after it has crossed into the video domain.
- R10: After reset the block is idle with the following outputs:
  - `word_ready` = 1;
  - `pix_stb` = 0;
  - `underrun` = 0;
  - `pix_out` = 0;
  - `scl_rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the scale register |
| vid_clk | input | 1 | Video clock that paces pixels and frames |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| scl_wr_en | input | 1 | Scale register write strobe (sys_clk) |
| scl_wr_data | input | 32 | Scale value: bits 19:12 pixel period, bits 11:0 frame period |
| scl_rd_data | output | 32 | Current scale register value, upper bits zero |
| word_valid | input | 1 | Next pixel word is available (vid_clk) |
| word_data | input | 32 | Next pixel word |
| word_mode | input | 1 | 0: sixteen 2-bit pixels, 1: thirty-two 1-bit pixels |
| word_ready | output | 1 | Block takes the word at this edge if `word_valid` is high |
| pix_out | output | 2 | Current pixel index |
| pix_stb | output | 1 | One-cycle pulse when a new pixel appears on `pix_out` |
| underrun | output | 1 | One-cycle pulse when a frame ends with no word waiting |

## Verification
Video-side results are timed in edges after the accepting edge E0:

| Result | Visible after |
|---|---|
| Pixel 0 and its strobe | E0 |
| Pixel k | edge k·P |
| `word_ready` high | edge F−1 |
| Next word's first pixel, or the underrun pulse | edge F |

The bench samples all of these on the falling edge of `vid_clk`, counting edges from acceptance.

Register readback is due one `sys_clk` edge after a write. A scale value needs a few video cycles to cross domains, so the bench leaves ten video cycles after each write before it offers a word. The exception is the mid-frame test, where the crossing deliberately overlaps a running frame.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
  localparam int WORD_W_DEF    = 32;
  localparam int PIX_PER_W_DEF = 8;
  localparam int FRM_PER_W_DEF = 12;
  localparam int REG_W_DEF     = 32;

  typedef enum logic {
    PM_DUAL = 1'b0,
    PM_MONO = 1'b1
  } pix_mode_e;
endpackage

// File: rtl/pixser_rst_sync.sv
module pixser_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pixser_down_ctr.sv
module pixser_down_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pixser_scale_xfer.sv
module pixser_scale_xfer #(
  parameter int SCALE_W     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic               sclk,
  input  logic               srst_n,
  input  logic               wr_en,
  input  logic [SCALE_W-1:0] wr_scale,
  output logic [SCALE_W-1:0] rd_scale,
  input  logic               vclk,
  input  logic               vrst_n,
  output logic [SCALE_W-1:0] pend_scale
);
  // system side: register and change toggle
  logic [SCALE_W-1:0] scale_q;
  logic               tog_q, tog_d;

  always_comb tog_d = ~tog_q;

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      scale_q <= '0;
      tog_q   <= 1'b0;
    end else if (wr_en) begin
      scale_q <= wr_scale;
      tog_q   <= tog_d;
    end
  end

  assign rd_scale = scale_q;

  // video side: toggle synchronizer chain
  logic [SYNC_STAGES-1:0] sync_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge vclk or negedge vrst_n) begin
          if (!vrst_n) sync_q[0] <= 1'b0;
          else         sync_q[0] <= tog_q;
        end
      end else begin : g_next
        always_ff @(posedge vclk or negedge vrst_n) begin
          if (!vrst_n) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  logic               seen_q;
  logic               capture;
  logic [SCALE_W-1:0] pend_q;

  always_comb capture = sync_q[SYNC_STAGES-1] ^ seen_q;

  always_ff @(posedge vclk or negedge vrst_n) begin
    if (!vrst_n) begin
      seen_q <= 1'b0;
      pend_q <= '0;
    end else if (capture) begin
      seen_q <= sync_q[SYNC_STAGES-1];
      pend_q <= scale_q;
    end
  end

  assign pend_scale = pend_q;
endmodule

// File: rtl/pixser_core.sv
module pixser_core
  import pixser_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int PIX_PER_W = 8,
  parameter int FRM_PER_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIX_PER_W-1:0] pix_per,
  input  logic [FRM_PER_W-1:0] frm_per,
  input  logic                 word_valid,
  input  logic [WORD_W-1:0]    word_data,
  input  logic                 word_mode,
  output logic                 word_ready,
  output logic [1:0]           pix_out,
  output logic                 pix_stb,
  output logic                 underrun
);
  localparam int LEFT_W = $clog2(WORD_W);
  localparam logic [LEFT_W-1:0] LAST_MONO = LEFT_W'(WORD_W - 1);
  localparam logic [LEFT_W-1:0] LAST_DUAL = LEFT_W'(WORD_W / 2 - 1);

  logic                 active_q, active_d, active_en;
  logic [WORD_W-1:0]    sh_q, sh_d;
  logic                 sh_en;
  pix_mode_e            mode_q;
  logic [LEFT_W-1:0]    left_q, left_d;
  logic [PIX_PER_W-1:0] rl_q;
  logic                 stb_q, stb_d;
  logic                 unr_q, unr_d;

  logic                 accept, shift, starve;
  logic                 p_zero, f_zero;
  logic                 p_load, p_dec, f_load, f_dec;
  logic [PIX_PER_W-1:0] p_load_val;
  logic [FRM_PER_W-1:0] f_load_val;

  // next-state logic
  always_comb begin
    word_ready = ~active_q | f_zero;
    accept     = word_ready & word_valid;
    starve     = active_q & f_zero & ~word_valid;
    shift      = active_q & ~f_zero & p_zero & (left_q != '0);

    p_load     = accept | (active_q & ~f_zero & p_zero);
    p_dec      = active_q & ~f_zero & ~p_zero;
    p_load_val = accept ? pix_per - PIX_PER_W'(1) : rl_q;
    f_load     = accept;
    f_dec      = active_q & ~f_zero;
    f_load_val = frm_per - FRM_PER_W'(1);

    active_en  = accept | starve;
    active_d   = accept;

    sh_en      = accept | shift;
    if (accept)                sh_d = word_data;
    else if (mode_q == PM_MONO) sh_d = sh_q >> 1;
    else                       sh_d = sh_q >> 2;

    if (accept) left_d = (word_mode == PM_MONO) ? LAST_MONO : LAST_DUAL;
    else        left_d = left_q - LEFT_W'(1);

    stb_d = accept | shift;
    unr_d = starve;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sh_q     <= '0;
      mode_q   <= PM_DUAL;
      left_q   <= '0;
      rl_q     <= '0;
      stb_q    <= 1'b0;
      unr_q    <= 1'b0;
    end else begin
      if (active_en) active_q <= active_d;
      if (sh_en)     sh_q     <= sh_d;
      if (sh_en)     left_q   <= left_d;
      if (accept) begin
        mode_q <= pix_mode_e'(word_mode);
        rl_q   <= pix_per - PIX_PER_W'(1);
      end
      stb_q <= stb_d;
      unr_q <= unr_d;
    end
  end

  pixser_down_ctr #(.W(PIX_PER_W)) u_pix_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (p_load),
    .load_val (p_load_val),
    .dec      (p_dec),
    .zero     (p_zero)
  );

  pixser_down_ctr #(.W(FRM_PER_W)) u_frm_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (f_load),
    .load_val (f_load_val),
    .dec      (f_dec),
    .zero     (f_zero)
  );

  assign pix_out  = (mode_q == PM_MONO) ? {1'b0, sh_q[0]} : sh_q[1:0];
  assign pix_stb  = stb_q;
  assign underrun = unr_q;
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
  import pixser_pkg::*;
#(
  parameter int WORD_W      = WORD_W_DEF,
  parameter int PIX_PER_W   = PIX_PER_W_DEF,
  parameter int FRM_PER_W   = FRM_PER_W_DEF,
  parameter int REG_W       = REG_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sys_clk,
  input  logic              vid_clk,
  input  logic              rst_n,
  input  logic              scl_wr_en,
  input  logic [REG_W-1:0]  scl_wr_data,
  output logic [REG_W-1:0]  scl_rd_data,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_mode,
  output logic              word_ready,
  output logic [1:0]        pix_out,
  output logic              pix_stb,
  output logic              underrun
);
  localparam int SCALE_W = PIX_PER_W + FRM_PER_W;

  logic               sys_rst_n, vid_rst_n;
  logic [SCALE_W-1:0] rd_scale, pend_scale;
  logic               unused_wr_hi;

  assign unused_wr_hi = ^scl_wr_data[REG_W-1:SCALE_W];

  pixser_rst_sync #(.STAGES(2)) u_sys_rst (
    .clk     (sys_clk),
    .arst_n  (rst_n),
    .rst_n_o (sys_rst_n)
  );

  pixser_rst_sync #(.STAGES(2)) u_vid_rst (
    .clk     (vid_clk),
    .arst_n  (rst_n),
    .rst_n_o (vid_rst_n)
  );

  pixser_scale_xfer #(.SCALE_W(SCALE_W), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .sclk       (sys_clk),
    .srst_n     (sys_rst_n),
    .wr_en      (scl_wr_en),
    .wr_scale   (scl_wr_data[SCALE_W-1:0]),
    .rd_scale   (rd_scale),
    .vclk       (vid_clk),
    .vrst_n     (vid_rst_n),
    .pend_scale (pend_scale)
  );

  assign scl_rd_data = REG_W'(rd_scale);

  pixser_core #(.WORD_W(WORD_W), .PIX_PER_W(PIX_PER_W), .FRM_PER_W(FRM_PER_W)) u_core (
    .clk        (vid_clk),
    .rst_n      (vid_rst_n),
    .pix_per    (pend_scale[SCALE_W-1:FRM_PER_W]),
    .frm_per    (pend_scale[FRM_PER_W-1:0]),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_mode  (word_mode),
    .word_ready (word_ready),
    .pix_out    (pix_out),
    .pix_stb    (pix_stb),
    .underrun   (underrun)
  );
endmodule

// File: rtl/pixser_chk.sv
module pixser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       word_valid,
  input logic       word_ready,
  input logic [1:0] pix_out,
  input logic       pix_stb,
  input logic       underrun
);
  a_r5_first_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> pix_stb);

  a_r8_underrun_single: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  a_r8_underrun_ready: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> word_ready);

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && !word_valid) |=> word_ready);

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_stb |-> $stable(pix_out));
endmodule

bind pixel_serializer pixser_chk u_chk (
  .clk        (vid_clk),
  .rst_n      (vid_rst_n),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .pix_out    (pix_out),
  .pix_stb    (pix_stb),
  .underrun   (underrun)
);

// File: tb/tb_pixel_serializer.sv
module tb_pixel_serializer;
  logic        sys_clk = 1'b0;
  logic        vid_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        scl_wr_en;
  logic [31:0] scl_wr_data;
  logic [31:0] scl_rd_data;
  logic        word_valid;
  logic [31:0] word_data;
  logic        word_mode;
  logic        word_ready;
  logic [1:0]  pix_out;
  logic        pix_stb;
  logic        underrun;

  int n_tests = 0;
  int n_fail  = 0;

  initial forever #2 sys_clk = ~sys_clk;
  initial forever #3 vid_clk = ~vid_clk;

  pixel_serializer dut (
    .sys_clk     (sys_clk),
    .vid_clk     (vid_clk),
    .rst_n       (rst_n),
    .scl_wr_en   (scl_wr_en),
    .scl_wr_data (scl_wr_data),
    .scl_rd_data (scl_rd_data),
    .word_valid  (word_valid),
    .word_data   (word_data),
    .word_mode   (word_mode),
    .word_ready  (word_ready),
    .pix_out     (pix_out),
    .pix_stb     (pix_stb),
    .underrun    (underrun)
  );

  // {mode, pixel field, frame field, data}
  localparam logic [52:0] VEC [7] = '{
    {1'b0, 8'd4, 12'd64, 32'hE4E4_1B1B},  // exact fit, 2-bit
    {1'b1, 8'd2, 12'd64, 32'hA5C3_0F96},  // exact fit, 1-bit
    {1'b0, 8'd5, 12'd40, 32'h1234_5678},  // frame ends early
    {1'b1, 8'd3, 12'd60, 32'h9E37_79B9},  // frame ends early
    {1'b0, 8'd2, 12'd50, 32'hFFFF_0001},  // pixels run out
    {1'b1, 8'd1, 12'd40, 32'h8000_0001},  // pixels run out
    {1'b0, 8'd3, 12'd3,  32'h0000_0002}   // one pixel only
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] px(logic m, logic [31:0] d, int k);
    if (m) return {1'b0, d[k]};
    return d[2*k +: 2];
  endfunction

  task automatic write_scale(logic [31:0] v);
    @(negedge sys_clk);
    scl_wr_en   = 1'b1;
    scl_wr_data = v;
    @(negedge sys_clk);
    scl_wr_en = 1'b0;
    repeat (10) @(negedge vid_clk);
  endtask

  task automatic start_word(logic m, logic [31:0] d);
    @(negedge vid_clk);
    word_valid = 1'b1;
    word_data  = d;
    word_mode  = m;
    while (!word_ready) @(negedge vid_clk);
    @(negedge vid_clk);
  endtask

  // Called at the first negedge after the accepting edge.
  task automatic watch_frame(logic m, logic [31:0] d, int p, int f,
                             bit nxt, logic nm, logic [31:0] nd, string ovr);
    int    np   = m ? 32 : 16;
    int    last = 0;
    bit    drop = ((np - 1) * p) > (f - 1);
    string ts   = (ovr != "") ? ovr : (drop ? "R6" : "R2");
    for (int c = 0; c < f; c++) begin
      bit es = ((c % p) == 0) && ((c / p) < np);
      if (c == 0) begin
        chk("R5", 32'(pix_stb), 32'd1, "strobe after accept");
        if (nxt) begin
          word_data = nd;
          word_mode = nm;
        end else begin
          word_valid = 1'b0;
        end
      end else begin
        chk(ts, 32'(pix_stb), 32'(es), "strobe timing");
      end
      if (es) last = c / p;
      chk(es ? "R4" : "R7", 32'(pix_out), 32'(px(m, d, last)), "pixel value");
      chk("R3", 32'(word_ready), 32'(c == f - 1), "ready at boundary only");
      chk("R8", 32'(underrun), 32'd0, "no underrun in frame");
      @(negedge vid_clk);
    end
    if (nxt) begin
      chk("R3", 32'(pix_stb), 32'd1, "next word strobe at F");
      chk("R3", 32'(pix_out), 32'(px(nm, nd, 0)), "next word pixel 0");
      chk("R8", 32'(underrun), 32'd0, "no underrun when fed");
    end else begin
      chk("R8", 32'(underrun), 32'd1, "underrun pulse");
      chk("R8", 32'(word_ready), 32'd1, "ready in stall");
      chk("R8", 32'(pix_stb), 32'd0, "no strobe in stall");
      @(negedge vid_clk);
      chk("R8", 32'(underrun), 32'd0, "underrun one cycle");
      chk("R8", 32'(pix_stb), 32'd0, "still stalled");
      chk("R7", 32'(pix_out), 32'(px(m, d, last)), "pixel held in stall");
    end
  endtask

  initial begin
    repeat (150000) @(posedge vid_clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    scl_wr_en   = 1'b0;
    scl_wr_data = '0;
    word_valid  = 1'b0;
    word_data   = '0;
    word_mode   = 1'b0;
    repeat (5) @(negedge vid_clk);
    rst_n = 1'b1;
    repeat (5) @(negedge vid_clk);

    // R10: reset state
    chk("R10", 32'(word_ready), 32'd1, "ready after reset");
    chk("R10", 32'(pix_stb), 32'd0, "strobe after reset");
    chk("R10", 32'(underrun), 32'd0, "underrun after reset");
    chk("R10", 32'(pix_out), 32'd0, "pixel after reset");
    chk("R10", scl_rd_data, 32'd0, "scale after reset");
    repeat (20) @(negedge vid_clk);
    chk("R8", 32'(underrun), 32'd0, "no underrun while idle");

    // R1: readback masks the unused upper bits
    write_scale(32'hFFF4_5123);
    chk("R1", scl_rd_data, 32'h0004_5123, "scale readback");

    // vector table walk
    for (int i = 0; i < 7; i++) begin
      logic        vm = VEC[i][52];
      logic [7:0]  vp = VEC[i][51:44];
      logic [11:0] vf = VEC[i][43:32];
      logic [31:0] vd = VEC[i][31:0];
      write_scale({12'h0, vp, vf});
      chk("R1", scl_rd_data, {12'h0, vp, vf}, "scale readback per vector");
      start_word(vm, vd);
      watch_frame(vm, vd, (vp == 0) ? 256 : int'(vp), (vf == 0) ? 4096 : int'(vf),
                  1'b0, 1'b0, 32'h0, "");
    end

    // R2 and R3: zero fields mean 256 and 4096 ticks
    write_scale(32'h0000_0000);
    start_word(1'b1, 32'h0000_FFFF);
    watch_frame(1'b1, 32'h0000_FFFF, 256, 4096, 1'b0, 1'b0, 32'h0, "R2");

    // R9: mid-frame scale change, back-to-back words
    write_scale({12'h0, 8'd2, 12'd32});
    start_word(1'b0, 32'h3C96_A55A);
    fork
      watch_frame(1'b0, 32'h3C96_A55A, 2, 32, 1'b1, 1'b1, 32'hC0DE_7E57, "R9");
      begin
        repeat (4) @(negedge vid_clk);
        write_scale({12'h0, 8'd3, 12'd30});
      end
    join
    watch_frame(1'b1, 32'hC0DE_7E57, 3, 30, 1'b0, 1'b0, 32'h0, "R9");
    chk("R1", scl_rd_data, 32'h0000_301E, "readback after change");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule